// File: doc/BRIEF.md
# LED Bounce Sequencer

This block lights one LED of a bank at a time and moves the lit position back and forth across the bank. It starts at the most significant output bit and walks down to the least significant bit. It then walks back up to the most significant bit and repeats without end.

The return pass repeats each end position, so the cycle is sixteen steps long for an eight-LED bank and the end LEDs stay lit for two dwell periods in a row. Each step is held for a dwell period built from two counters. A prescaler divides the clock into ticks, and a dwell counter counts a fixed number of those ticks. The defaults give about 200 ms per step from a 250 MHz clock.

A run enable starts and pauses the sequence. An active-low bank enable output switches the whole bank on or off.

Top module: `led_bounce_seq`

## Requirements
- R1: Outside reset, exactly one bit of `led_pat` is high on every cycle.
- R2: Step index i (counting from 0) shows bit `LED_W-1-i` for i < `LED_W` and bit `i-LED_W` for `LED_W` <= i < 2·`LED_W`. With `LED_W`=8 this gives 0x80,0x40,…,0x01, then 0x01,0x02,…,0x80.
- R3: After the last step (index 2·`LED_W`-1, pattern 0x80) the sequence wraps to index 0 (pattern 0x80) and keeps running.
- R4: Each step lasts exactly `TICK_DIV`·`DWELL_TICKS` clock cycles with `run_en` high. The index changes only at the rising edge that ends the last cycle of that count.
- R5: A synchronous reset (`rst_n` low at a rising edge) sets index 0 (pattern 0x80), clears both counters and drives `led_en_n` high. After reset is released, a full dwell period must pass before the first advance.
- R6: While `run_en` is low, the pattern and the dwell progress are held. When `run_en` goes high again, the step continues from the point where it paused.
- R7: `led_en_n` takes the inverse of the `run_en` value seen at the previous rising edge. A low level lights the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | High to advance the sequence and light the bank |
| led_pat | output | LED_W | One-hot LED pattern |
| led_en_n | output | 1 | Bank enable, active low |

## Verification
The assertions assume that `rst_n` is held low for at least one rising edge at the start. They also assume that `run_en` is a clean synchronous level, free of glitches between edges. The bench drives both inputs only on falling clock edges and asserts reset for several cycles before any other stimulus.

Random on/off bursts of `run_en` exercise the pause and resume behaviour. A reset is injected partway through a dwell period to check that it restarts the full count. Short prescale and dwell values let the bench pass through several complete sixteen-step cycles, including the wrap.

// File: rtl/led_bounce_pkg.sv
// Package: shared constants and helpers for the LED bounce sequencer.
// Assumes the bank width is at least 2.
package led_bounce_pkg;

    // Number of passes over the bank per cycle: one down, one up.
    localparam int unsigned SWEEP_PASSES = 2;

    // Width of a counter that must hold values 0..n-1 (at least 1 bit).
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lbs_tick_timer.sv
// Module: dwell timer. A prescaler divides the clock into ticks, and a
// dwell counter counts ticks. step_o pulses for one cycle on the last
// cycle of each dwell period. Both counters hold while run_i is low.
// Assumes TICK_DIV >= 1 and DWELL_TICKS >= 1.
module lbs_tick_timer
    import led_bounce_pkg::*;
#(
    parameter int unsigned TICK_DIV    = 250000,
    parameter int unsigned DWELL_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic step_o
);
    localparam int unsigned PRE_W = cnt_width(TICK_DIV);
    localparam int unsigned DW_W  = cnt_width(DWELL_TICKS);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
    localparam logic [DW_W-1:0]  DW_LAST  = DW_W'(DWELL_TICKS - 1);

    logic [PRE_W-1:0] pre_q;
    logic [DW_W-1:0]  dw_q;
    logic             tick;

    assign tick   = run_i && (pre_q == PRE_LAST);
    assign step_o = tick && (dw_q == DW_LAST);

    // Prescaler: counts run cycles, wraps at TICK_DIV.
    always_ff @(posedge clk) begin
        if (!rst_n)        pre_q <= '0;
        else if (tick)     pre_q <= '0;
        else if (run_i)    pre_q <= pre_q + 1'b1;
    end

    // Dwell counter: counts ticks, wraps at DWELL_TICKS.
    always_ff @(posedge clk) begin
        if (!rst_n)        dw_q <= '0;
        else if (step_o)   dw_q <= '0;
        else if (tick)     dw_q <= dw_q + 1'b1;
    end

    AST_STEP_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> run_i);                                     // R6
    AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(pre_q) && $stable(dw_q));           // R6
    AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= PRE_LAST && dw_q <= DW_LAST);                 // R4

endmodule

// File: rtl/lbs_step_index.sv
// Module: step index register. Advances once per step pulse and wraps
// after the last step of the bounce cycle.
// Assumes step_i is a single-cycle pulse.
module lbs_step_index
    import led_bounce_pkg::*;
#(
    parameter int unsigned N_STEPS = 16,
    parameter int unsigned IDX_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_STEPS - 1);

    // Index register: reset to 0, advance on step, wrap after LAST.
    always_ff @(posedge clk) begin
        if (!rst_n)                       idx_o <= '0;
        else if (step_i && idx_o == LAST) idx_o <= '0;
        else if (step_i)                  idx_o <= idx_o + 1'b1;
    end

    AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && idx_o != LAST |=> idx_o == $past(idx_o) + 1'b1); // R2
    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && idx_o == LAST |=> idx_o == '0);                   // R3
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(idx_o));                                // R4

endmodule

// File: rtl/lbs_pattern_dec.sv
// Module: maps a step index to a one-hot LED pattern. Indices below
// LED_W walk down from the top bit, and the rest walk back up from bit 0.
// Assumes idx_i < 2*LED_W.
module lbs_pattern_dec #(
    parameter int unsigned LED_W = 8,
    parameter int unsigned IDX_W = 4
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [LED_W-1:0] pat_o
);
    // One compare pair per LED: lit on the down pass and on the up pass.
    for (genvar b = 0; b < LED_W; b++) begin : g_bit
        localparam logic [IDX_W-1:0] DOWN_IDX = IDX_W'(LED_W - 1 - b);
        localparam logic [IDX_W-1:0] UP_IDX   = IDX_W'(LED_W + b);
        assign pat_o[b] = (idx_i == DOWN_IDX) || (idx_i == UP_IDX);
    end

    always_comb begin
        AST_ONE_LIT: assert ($countones(pat_o) <= 1);               // R1
    end

endmodule

// File: rtl/led_bounce_seq.sv
// Module: LED bounce sequencer top. Lights one LED at a time and sweeps
// the bank down and then back up, with each step held for
// TICK_DIV*DWELL_TICKS cycles. The bank enable is active low.
// Assumes rst_n is synchronous to clk and LED_W >= 2.
module led_bounce_seq
    import led_bounce_pkg::*;
#(
    parameter int unsigned LED_W       = 8,
    parameter int unsigned TICK_DIV    = 250000,
    parameter int unsigned DWELL_TICKS = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    output logic [LED_W-1:0] led_pat,
    output logic             led_en_n
);
    localparam int unsigned N_STEPS = SWEEP_PASSES * LED_W;
    localparam int unsigned IDX_W   = cnt_width(N_STEPS);

    logic             step;
    logic [IDX_W-1:0] idx;

    lbs_tick_timer #(
        .TICK_DIV    (TICK_DIV),
        .DWELL_TICKS (DWELL_TICKS)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run_en),
        .step_o (step)
    );

    lbs_step_index #(
        .N_STEPS (N_STEPS),
        .IDX_W   (IDX_W)
    ) u_index (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step),
        .idx_o  (idx)
    );

    lbs_pattern_dec #(
        .LED_W (LED_W),
        .IDX_W (IDX_W)
    ) u_dec (
        .idx_i (idx),
        .pat_o (led_pat)
    );

    // Bank enable: register the inverse of run_en; dark during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) led_en_n <= 1'b1;
        else        led_en_n <= ~run_en;
    end

    AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(led_pat) == 1);                                  // R1
    AST_RESET_TOP: assert property (@(posedge clk)
        !rst_n |=> led_pat == LED_W'(1) << (LED_W - 1) && led_en_n); // R5
    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(led_pat));                              // R6
    AST_EN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> !led_en_n);                                      // R7
    AST_EN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> led_en_n);                                      // R7

endmodule

// File: tb/led_bounce_seq_tb.sv
// Bench: random run/pause stimulus plus directed reset and wrap cases.
// Outputs are compared against a cycle-count reference model.
module led_bounce_seq_tb;
    localparam int unsigned W     = 8;
    localparam int unsigned DIV   = 3;
    localparam int unsigned DWELL = 4;
    localparam int unsigned HOLD  = DIV * DWELL;
    localparam int unsigned CYCLE = HOLD * 2 * W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run_en = 1'b0;
    logic [W-1:0] led_pat;
    logic         led_en_n;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    int unsigned run_cnt = 0;
    logic        exp_en_n = 1'b1;
    int unsigned seed = 32'h1d2c3b4a;

    always #2 clk = ~clk;

    led_bounce_seq #(.LED_W(W), .TICK_DIV(DIV), .DWELL_TICKS(DWELL)) u_dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .led_pat(led_pat), .led_en_n(led_en_n)
    );

    // Expected pattern for a step index, written out for the 8-LED bank.
    function automatic logic [7:0] exp_pat(input int unsigned i);
        logic [7:0] tab [16] = '{8'h80, 8'h40, 8'h20, 8'h10, 8'h08, 8'h04,
                                 8'h02, 8'h01, 8'h01, 8'h02, 8'h04, 8'h08,
                                 8'h10, 8'h20, 8'h40, 8'h80};
        return tab[i];
    endfunction

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, update the model after the posedge,
    // and compare at the following negedge.
    task automatic cycle(input logic rst_v, input logic run_v);
        int unsigned idx;
        string tag;
        rst_n  = rst_v;
        run_en = run_v;
        @(posedge clk);
        #1;
        if (!rst_v) begin
            run_cnt  = 0;
            exp_en_n = 1'b1;
        end else begin
            if (run_v) run_cnt = (run_cnt + 1) % CYCLE;
            exp_en_n = ~run_v;
        end
        @(negedge clk);
        idx = run_cnt / HOLD;
        if (!rst_v)                                  tag = "R5";
        else if (!run_v)                             tag = "R6";
        else if (run_cnt == 0)                       tag = "R3";
        else if (run_cnt % HOLD == 0)                tag = "R4";
        else                                         tag = "R2";
        check(tag, 32'(led_pat), 32'(exp_pat(idx)));
        check("R7", 32'(led_en_n), 32'(exp_en_n));
        if (rst_v) check("R1", 32'($countones(led_pat)), 32'd1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(seed));
        @(negedge clk);
        // R5: reset state.
        for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1);
        // R4 R3: two full uninterrupted cycles, including the wrap.
        for (int i = 0; i < 2 * CYCLE; i++) cycle(1'b1, 1'b1);
        // R6: pause mid-dwell, then resume.
        for (int i = 0; i < 5; i++) cycle(1'b1, 1'b1);
        for (int i = 0; i < 20; i++) cycle(1'b1, 1'b0);
        for (int i = 0; i < 30; i++) cycle(1'b1, 1'b1);
        // R5: reset partway through a dwell restarts the count.
        cycle(1'b0, 1'b1);
        for (int i = 0; i < HOLD + 2; i++) cycle(1'b1, 1'b1);
        // Random run/pause bursts.
        for (int i = 0; i < 3000; i++) begin
            cycle(($urandom % 400) != 0, ($urandom % 5) != 0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule